// File: doc/BRIEF.md
# Interrupt Holding-Register Control Unit

This unit handles interrupts for a small 32-bit RISC-V core that keeps its interrupt state outside the CSR space. A bank of holding registers (H0 to H3) holds the interrupt context. An interrupt mask register and a pending register decide when an interrupt is taken. Four custom R-type instructions in the custom-0 opcode space move values between the general registers and this state. The core presents each retiring instruction word together with the value of its rs1 operand and the address of the next instruction to run. The unit answers one cycle later with an optional write to the general register file, an optional PC redirect, or both suppressed.

When at least one pending source is unmasked and no handler is running, the unit takes an interrupt. H0 records the resume address. H1 records the bitmap of the sources being serviced. The core is then redirected to the IRQ vector, which sits 0x10 above the reset vector. Handlers cannot nest. Anything that arrives during a handler is held until the return instruction runs. An undefined encoding in the custom-0 space is reported as an illegal-instruction interrupt on source bit 1.

Top module: `irq_qctl`

## Requirements
- R1: After reset the mask register is all ones, no handler is active and all outputs are zero. While every source is masked, raised interrupt lines cause no redirect.
- R2: A holding-register write (opcode 0001011, funct7 0000001, funct3 010) copies rs1_val into the holding register named by the rd field. A holding-register read (funct7 0000000, funct3 100) returns the holding register named by the rs1 field. The read result appears on rd_wdata with rd_we high and rd_addr equal to the rd field, one cycle after the instruction is presented.
- R3: A mask swap (funct7 0000011, funct3 110) returns the previous mask on rd_wdata one cycle later and loads the mask from rs1_val. A set mask bit blocks its source.
- R4: When (pending AND NOT mask) is non-zero and no handler is active, the next cycle shows redir_valid with redir_pc = reset vector + 0x10. H0 then holds the cur_pc of the entry cycle, and H1 holds exactly the delivered bitmap.
- R5: On entry the delivered pending bits are cleared. Masked pending bits and sources that arrive later accumulate, and a later entry delivers them together.
- R6: While a handler is active no further entry happens, whatever the pending and mask state.
- R7: A return instruction (funct7 0000010, funct3 000, rd, rs1 and rs2 fields all zero) redirects to the value in H0 one cycle later and ends the active handler.
- R8: Any custom-0 encoding whose funct7/funct3 pair is not one of the four listed sets pending bit 1. No register write and no redirect results from it directly.
- R9: An instruction presented in the cycle an interrupt is taken is discarded: it writes nothing and changes no state.
- R10: Instructions with an opcode other than 0001011 are ignored: no register write and no pending bit.
- R11: A holding-register read or write whose select field is 4 or above, and a return encoding with a non-zero register field, count as illegal (pending bit 1) and have no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction retires this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | XLEN | Value of general register rs1 |
| cur_pc | input | XLEN | Address of the next instruction to run (resume address) |
| irq_raw | input | XLEN | Raw interrupt lines, one per source bit |
| rd_we | output | 1 | General register write enable |
| rd_addr | output | 5 | General register index to write |
| rd_wdata | output | XLEN | General register write data |
| redir_valid | output | 1 | PC redirect request |
| redir_pc | output | XLEN | Redirect target |

## Verification
Register reads, mask swaps and returns show their result at the first clock edge after the instruction is presented. An interrupt line or an illegal encoding needs two edges before the vector redirect: one to register the pending bit and one to take the entry. The bench drives every stimulus just after a falling edge and samples on the following falling edge. For the two-edge paths it checks the first sample for absence and the second for the redirect. The sweep over every funct7 value from 0 to 7 against every funct3 value follows that same three-step pattern for each undefined pair.

// File: rtl/irq_qctl_pkg.sv
package irq_qctl_pkg;

   localparam logic [6:0] OPC_CUST0 = 7'b0001011;

   localparam logic [6:0] F7_HREAD  = 7'b0000000;
   localparam logic [6:0] F7_HWRITE = 7'b0000001;
   localparam logic [6:0] F7_IRET   = 7'b0000010;
   localparam logic [6:0] F7_MSWAP  = 7'b0000011;

   localparam logic [2:0] F3_HREAD  = 3'b100;
   localparam logic [2:0] F3_HWRITE = 3'b010;
   localparam logic [2:0] F3_IRET   = 3'b000;
   localparam logic [2:0] F3_MSWAP  = 3'b110;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_HREAD,
      OP_HWRITE,
      OP_IRET,
      OP_MSWAP,
      OP_BAD
   } qop_e;

   typedef struct packed {
      qop_e       op;
      logic [4:0] rd;
      logic [4:0] rs1;
   } qdec_t;

endpackage

// File: rtl/irq_qctl_decode.sv
module irq_qctl_decode
   import irq_qctl_pkg::*;
#(
   parameter int NUM_Q = 4
) (
   input  logic        valid,
   input  logic [31:0] instr,
   output qdec_t       dec
);

   logic [6:0] opc;
   logic [6:0] f7;
   logic [2:0] f3;
   logic [4:0] f_rd;
   logic [4:0] f_rs1;
   logic [4:0] f_rs2;
   logic       sel_rs1_ok;
   logic       sel_rd_ok;
   logic       regs_zero;

   assign opc   = instr[6:0];
   assign f_rd  = instr[11:7];
   assign f3    = instr[14:12];
   assign f_rs1 = instr[19:15];
   assign f_rs2 = instr[24:20];
   assign f7    = instr[31:25];

   assign sel_rs1_ok = (int'(f_rs1) < NUM_Q);
   assign sel_rd_ok  = (int'(f_rd) < NUM_Q);
   assign regs_zero  = (f_rd == 5'd0) && (f_rs1 == 5'd0) && (f_rs2 == 5'd0);

   always_comb begin
      dec.op  = OP_NONE;
      dec.rd  = f_rd;
      dec.rs1 = f_rs1;
      if (valid && (opc == OPC_CUST0)) begin
         if ((f7 == F7_HREAD) && (f3 == F3_HREAD)) begin
            dec.op = sel_rs1_ok ? OP_HREAD : OP_BAD;
         end else if ((f7 == F7_HWRITE) && (f3 == F3_HWRITE)) begin
            dec.op = sel_rd_ok ? OP_HWRITE : OP_BAD;
         end else if ((f7 == F7_IRET) && (f3 == F3_IRET)) begin
            dec.op = regs_zero ? OP_IRET : OP_BAD;
         end else if ((f7 == F7_MSWAP) && (f3 == F3_MSWAP)) begin
            dec.op = OP_MSWAP;
         end else begin
            dec.op = OP_BAD;
         end
      end
   end

endmodule

// File: rtl/irq_qctl_hold.sv
module irq_qctl_hold #(
   parameter int XLEN  = 32,
   parameter int NUM_Q = 4,
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [XLEN-1:0]  wr_data,
   input  logic             entry,
   input  logic [XLEN-1:0]  entry_pc,
   input  logic [XLEN-1:0]  entry_bits,
   input  logic [SEL_W-1:0] rd_sel,
   output logic [XLEN-1:0]  rd_data,
   output logic [XLEN-1:0]  h0_data
);

   logic [XLEN-1:0] hold_q [NUM_Q];

   for (genvar g = 0; g < NUM_Q; g++) begin : g_hold
      logic wr_hit;
      assign wr_hit = wr_en && (wr_sel == SEL_W'(g));

      if (g == 0) begin : g_resume
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       hold_q[g] <= '0;
            else if (entry)   hold_q[g] <= entry_pc;
            else if (wr_hit)  hold_q[g] <= wr_data;
         end
      end else if (g == 1) begin : g_cause
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       hold_q[g] <= '0;
            else if (entry)   hold_q[g] <= entry_bits;
            else if (wr_hit)  hold_q[g] <= wr_data;
         end
      end else begin : g_scratch
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       hold_q[g] <= '0;
            else if (wr_hit)  hold_q[g] <= wr_data;
         end
      end
   end

   assign rd_data = hold_q[rd_sel];
   assign h0_data = hold_q[0];

endmodule

// File: rtl/irq_qctl_gate.sv
module irq_qctl_gate #(
   parameter int              XLEN      = 32,
   parameter int              ILL_BIT   = 1,
   parameter logic [XLEN-1:0] MASK_INIT = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [XLEN-1:0] raw,
   input  logic            ill_set,
   input  logic            mask_wr,
   input  logic [XLEN-1:0] mask_wdata,
   input  logic            ret_exec,
   output logic            take,
   output logic [XLEN-1:0] deliver,
   output logic [XLEN-1:0] mask_q,
   output logic [XLEN-1:0] pend_q,
   output logic            active_q
);

   localparam logic [XLEN-1:0] ILL_ONEHOT = XLEN'(1) << ILL_BIT;

   logic [XLEN-1:0] ready;
   logic [XLEN-1:0] pend_d;

   assign ready   = pend_q & ~mask_q;
   assign take    = !active_q && (ready != '0);
   assign deliver = take ? ready : '0;

   always_comb begin
      pend_d = (pend_q & ~deliver) | raw;
      if (ill_set) pend_d = pend_d | ILL_ONEHOT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= '0;
         mask_q   <= MASK_INIT;
         active_q <= 1'b0;
      end else begin
         pend_q <= pend_d;
         if (mask_wr) mask_q <= mask_wdata;
         if (take)          active_q <= 1'b1;
         else if (ret_exec) active_q <= 1'b0;
      end
   end

endmodule

// File: rtl/irq_qctl.sv
module irq_qctl
   import irq_qctl_pkg::*;
#(
   parameter int              XLEN      = 32,
   parameter int              NUM_Q     = 4,
   parameter logic [XLEN-1:0] RESET_VEC = '0,
   parameter logic [XLEN-1:0] VEC_OFS   = XLEN'(16),
   parameter int              ILL_BIT   = 1,
   parameter logic [XLEN-1:0] MASK_INIT = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            instr_valid,
   input  logic [31:0]     instr,
   input  logic [XLEN-1:0] rs1_val,
   input  logic [XLEN-1:0] cur_pc,
   input  logic [XLEN-1:0] irq_raw,
   output logic            rd_we,
   output logic [4:0]      rd_addr,
   output logic [XLEN-1:0] rd_wdata,
   output logic            redir_valid,
   output logic [XLEN-1:0] redir_pc
);

   localparam int              SEL_W   = $clog2(NUM_Q);
   localparam logic [XLEN-1:0] IRQ_VEC = RESET_VEC + VEC_OFS;

   if (NUM_Q < 2 || NUM_Q > 32 || (NUM_Q & (NUM_Q - 1)) != 0) begin : g_bad_numq
      $error("NUM_Q must be a power of two between 2 and 32");
   end
   if (ILL_BIT < 0 || ILL_BIT >= XLEN) begin : g_bad_illbit
      $error("ILL_BIT must index a source bit");
   end
   if (XLEN < 8) begin : g_bad_xlen
      $error("XLEN too small");
   end

   qdec_t           dec;
   logic            take;
   logic [XLEN-1:0] deliver;
   logic [XLEN-1:0] irq_mask;
   logic [XLEN-1:0] irq_pend;
   logic            irq_active;
   logic [XLEN-1:0] hold_rdata;
   logic [XLEN-1:0] hold_h0;

   logic do_read;
   logic do_write;
   logic do_ret;
   logic do_swap;
   logic do_bad;

   irq_qctl_decode #(.NUM_Q(NUM_Q)) u_dec (
      .valid (instr_valid),
      .instr (instr),
      .dec   (dec)
   );

   assign do_read  = !take && (dec.op == OP_HREAD);
   assign do_write = !take && (dec.op == OP_HWRITE);
   assign do_ret   = !take && (dec.op == OP_IRET);
   assign do_swap  = !take && (dec.op == OP_MSWAP);
   assign do_bad   = !take && (dec.op == OP_BAD);

   irq_qctl_gate #(
      .XLEN      (XLEN),
      .ILL_BIT   (ILL_BIT),
      .MASK_INIT (MASK_INIT)
   ) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw        (irq_raw),
      .ill_set    (do_bad),
      .mask_wr    (do_swap),
      .mask_wdata (rs1_val),
      .ret_exec   (do_ret),
      .take       (take),
      .deliver    (deliver),
      .mask_q     (irq_mask),
      .pend_q     (irq_pend),
      .active_q   (irq_active)
   );

   irq_qctl_hold #(
      .XLEN  (XLEN),
      .NUM_Q (NUM_Q),
      .SEL_W (SEL_W)
   ) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (do_write),
      .wr_sel     (dec.rd[SEL_W-1:0]),
      .wr_data    (rs1_val),
      .entry      (take),
      .entry_pc   (cur_pc),
      .entry_bits (deliver),
      .rd_sel     (dec.rs1[SEL_W-1:0]),
      .rd_data    (hold_rdata),
      .h0_data    (hold_h0)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_we       <= 1'b0;
         rd_addr     <= '0;
         rd_wdata    <= '0;
         redir_valid <= 1'b0;
         redir_pc    <= '0;
      end else begin
         rd_we       <= do_read || do_swap;
         redir_valid <= take || do_ret;
         if (do_read || do_swap) begin
            rd_addr  <= dec.rd;
            rd_wdata <= do_swap ? irq_mask : hold_rdata;
         end
         if (take)        redir_pc <= IRQ_VEC;
         else if (do_ret) redir_pc <= hold_h0;
      end
   end

endmodule

// File: rtl/irq_qctl_chk.sv
module irq_qctl_chk #(
   parameter int              XLEN    = 32,
   parameter logic [XLEN-1:0] IRQ_VEC = XLEN'(16)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            instr_valid,
   input logic [31:0]     instr,
   input logic [XLEN-1:0] irq_raw,
   input logic            rd_we,
   input logic            redir_valid,
   input logic [XLEN-1:0] redir_pc,
   input logic            active,
   input logic [XLEN-1:0] pend,
   input logic [XLEN-1:0] mask
);

   logic is_ret;
   logic want;

   assign is_ret = instr_valid && (instr[6:0] == 7'b0001011) &&
                   (instr[31:25] == 7'b0000010) && (instr[24:7] == 18'd0);
   assign want   = !active && ((pend & ~mask) != '0);

   // R4: an unmasked pending source with no handler leads to entry at the vector
   p_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      want |=> (redir_valid && active && redir_pc == IRQ_VEC));

   // R5: delivered bits leave the pending register unless raised again
   p_pend_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      want |=> ((pend & $past(pend & ~mask)) == ($past(irq_raw) & $past(pend & ~mask))));

   // R6: no nested entry while a handler runs
   p_no_nest_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !is_ret) |=> (active && !redir_valid));

   // R7: return ends the handler with a redirect
   p_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && is_ret) |=> (redir_valid && !active));

   // R9: the instruction in the entry cycle writes nothing
   p_squash_r9: assert property (@(posedge clk) disable iff (!rst_n)
      want |=> !rd_we);

   // R7: a redirect and a register write never coincide
   p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_we, redir_valid}));

endmodule

bind irq_qctl irq_qctl_chk #(.XLEN(XLEN), .IRQ_VEC(IRQ_VEC)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr       (instr),
   .irq_raw     (irq_raw),
   .rd_we       (rd_we),
   .redir_valid (redir_valid),
   .redir_pc    (redir_pc),
   .active      (irq_active),
   .pend        (irq_pend),
   .mask        (irq_mask)
);

// File: tb/tb_irq_qctl.sv
module tb_irq_qctl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        instr_valid;
   logic [31:0] instr;
   logic [31:0] rs1_val;
   logic [31:0] cur_pc;
   logic [31:0] irq_raw;
   logic        rd_we;
   logic [4:0]  rd_addr;
   logic [31:0] rd_wdata;
   logic        redir_valid;
   logic [31:0] redir_pc;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   localparam logic [31:0] VEC = 32'h10;

   always #10 clk = ~clk;

   irq_qctl dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .instr       (instr),
      .rs1_val     (rs1_val),
      .cur_pc      (cur_pc),
      .irq_raw     (irq_raw),
      .rd_we       (rd_we),
      .rd_addr     (rd_addr),
      .rd_wdata    (rd_wdata),
      .redir_valid (redir_valid),
      .redir_pc    (redir_pc)
   );

   function automatic logic [31:0] enc(int f7, int f3, int rd, int rs1, int rs2);
      return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), 7'b0001011};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(logic v, logic [31:0] ins, logic [31:0] r1, logic [31:0] raw);
      instr_valid = v;
      instr       = ins;
      rs1_val     = r1;
      irq_raw     = raw;
      @(posedge clk);
      @(negedge clk);
      instr_valid = 1'b0;
      instr       = '0;
      rs1_val     = '0;
      irq_raw     = '0;
   endtask

   task automatic idle();
      cyc(1'b0, 32'h0, 32'h0, 32'h0);
   endtask

   task automatic hread(int sel, int rd);
      cyc(1'b1, enc(0, 4, rd, sel, 0), 32'h0, 32'h0);
   endtask

   task automatic hwrite(int sel, logic [31:0] val);
      cyc(1'b1, enc(1, 2, sel, 0, 0), val, 32'h0);
   endtask

   task automatic iret();
      cyc(1'b1, enc(2, 0, 0, 0, 0), 32'h0, 32'h0);
   endtask

   task automatic mswap(int rd, logic [31:0] val);
      cyc(1'b1, enc(3, 6, rd, 0, 0), val, 32'h0);
   endtask

   // illegal stimulus already applied: expect entry one cycle later with H1 = 2
   task automatic expect_ill_entry(string tag, logic [31:0] pc);
      chk({tag, " no direct redirect"}, 32'(redir_valid), 32'd0);
      cur_pc = pc;
      idle();
      chk({tag, " entry"}, 32'(redir_valid), 32'd1);
      chk({tag, " vector"}, redir_pc, VEC);
      hread(1, 7);
      chk({tag, " H1 cause"}, rd_wdata, 32'h2);
      iret();
      chk({tag, " return pc"}, redir_pc, pc);
      idle();
      chk({tag, " cleared"}, 32'(redir_valid), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; instr_valid = 1'b0; instr = '0; rs1_val = '0;
      cur_pc = '0; irq_raw = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1 rd_we", 32'(rd_we), 32'd0);
      chk("R1 redir", 32'(redir_valid), 32'd0);
      chk("R1 wdata", rd_wdata, 32'd0);
      cyc(1'b0, 32'h0, 32'h0, 32'hFFFF_FFFF);
      for (int i = 0; i < 3; i++) begin
         idle();
         chk("R1 masked sources no redirect", 32'(redir_valid), 32'd0);
      end

      // R2: holding register write/read
      for (int q = 0; q < 4; q++) begin
         hwrite(q, 32'hC0DE_0000 | q);
         chk("R2 write no rd_we", 32'(rd_we), 32'd0);
      end
      for (int q = 0; q < 4; q++) begin
         hread(q, q + 8);
         chk("R2 read rd_we", 32'(rd_we), 32'd1);
         chk("R2 read rd_addr", 32'(rd_addr), 32'(q + 8));
         chk("R2 read data", rd_wdata, 32'hC0DE_0000 | q);
      end

      // R3: mask swap returns reset mask, unblocks bit 0
      mswap(5, 32'hFFFF_FFFE);
      chk("R3 rd_we", 32'(rd_we), 32'd1);
      chk("R3 rd_addr", 32'(rd_addr), 32'd5);
      chk("R3 old mask", rd_wdata, 32'hFFFF_FFFF);

      // R4/R9: entry cycle, presented read is discarded
      cur_pc = 32'h0000_0100;
      hread(2, 3);
      chk("R9 squashed rd_we", 32'(rd_we), 32'd0);
      chk("R4 redirect", 32'(redir_valid), 32'd1);
      chk("R4 vector", redir_pc, VEC);
      hread(1, 4);
      chk("R4 H1 bitmap", rd_wdata, 32'h1);
      hread(0, 4);
      chk("R4 H0 resume pc", rd_wdata, 32'h100);
      hread(2, 4);
      chk("R9 H2 untouched", rd_wdata, 32'hC0DE_0002);

      // R6: no nesting
      cyc(1'b0, 32'h0, 32'h0, 32'h1);
      chk("R6 no nest a", 32'(redir_valid), 32'd0);
      idle();
      chk("R6 no nest b", 32'(redir_valid), 32'd0);
      mswap(6, 32'hFFFF_FFFC);
      chk("R3 old mask second", rd_wdata, 32'hFFFF_FFFE);
      idle();
      chk("R6 still held", 32'(redir_valid), 32'd0);

      // R7: return, then R5 accumulated entry
      iret();
      chk("R7 return redirect", 32'(redir_valid), 32'd1);
      chk("R7 return pc", redir_pc, 32'h100);
      idle();
      chk("R5 re-entry", 32'(redir_valid), 32'd1);
      chk("R5 re-entry vector", redir_pc, VEC);
      hread(1, 2);
      chk("R5 accumulated bitmap", rd_wdata, 32'h3);
      mswap(0, 32'hFFFF_FFFD);
      iret();
      chk("R7 return pc second", redir_pc, 32'h100);
      idle();
      chk("R5 delivered cleared", 32'(redir_valid), 32'd0);

      // R10: foreign opcode ignored
      cyc(1'b1, {7'd3, 5'd0, 5'd0, 3'd6, 5'd1, 7'b0110011}, 32'h0, 32'h0);
      chk("R10 no rd_we", 32'(rd_we), 32'd0);
      idle();
      chk("R10 no pending", 32'(redir_valid), 32'd0);
      idle();
      chk("R10 no pending later", 32'(redir_valid), 32'd0);

      // R8: sweep of funct7 0..7 against funct3 0..7
      for (int f7 = 0; f7 < 8; f7++) begin
         for (int f3 = 0; f3 < 8; f3++) begin
            if ((f7 == 0 && f3 == 4) || (f7 == 1 && f3 == 2) ||
                (f7 == 2 && f3 == 0) || (f7 == 3 && f3 == 6)) continue;
            cyc(1'b1, enc(f7, f3, 0, 0, 0), 32'h0, 32'h0);
            chk("R8 no rd_we", 32'(rd_we), 32'd0);
            expect_ill_entry("R8", 32'h200 + 32'(f7 * 8 + f3) * 4);
         end
      end

      // R11: out-of-range selects and malformed return
      cyc(1'b1, enc(0, 4, 1, 4, 0), 32'h0, 32'h0);
      chk("R11 bad read no rd_we", 32'(rd_we), 32'd0);
      expect_ill_entry("R11 read sel", 32'h400);
      cyc(1'b1, enc(1, 2, 5, 0, 0), 32'h1234_5678, 32'h0);
      expect_ill_entry("R11 write sel", 32'h404);
      for (int q = 2; q < 4; q++) begin
         hread(q, 1);
         chk("R11 scratch untouched", rd_wdata, 32'hC0DE_0000 | q);
      end
      cyc(1'b1, enc(2, 0, 0, 0, 3), 32'h0, 32'h0);
      expect_ill_entry("R11 return fields", 32'h408);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule